// File: doc/BRIEF.md
# Bimodal Branch Predictor with Target Buffer

This block is a direct-mapped prediction table for the fetch stage of a processor. Each row holds a valid bit, an address tag, a two-bit saturating direction counter and a predicted target address. The fetch stage presents a fetch address every cycle. One clock later the block reports whether that address is predicted as a taken branch, and gives the target to redirect to.

When a branch resolves in the execute stage, the pipeline sends back the fetch address of the resolved instruction. It also sends three facts about it: whether it belongs to the trainable branch classes, whether it was taken, and its actual target. The trainable classes are immediate conditional or linking branches, moves or adds into the program counter, and loads or block loads that write the program counter. The block then trains, allocates or invalidates the row.

There is no enable and no software control. The table is always active. A row that claimed a branch where the resolved instruction is not a trainable branch clears itself.

Top module: `bp_predictor`

## Requirements
- R1: After reset every row is invalid, so no lookup predicts taken and `predTarget` reads zero until a row is allocated.
- R2: A lookup is registered. The address on `lookupPc` at one rising edge produces `predTaken`/`predTarget` after that edge. `predTarget` is zero whenever `predTaken` is low.
- R3: The row index is `pc[log2(DEPTH)+1:2]` and the tag is `pc[AW-1:log2(DEPTH)+2]`. An address with the same index but a different tag does not hit.
- R4: A taken trainable update that misses allocates the row. It writes the tag, the target and counter state 2 (weakly taken), so the next lookup predicts taken with that target.
- R5: A not-taken trainable update that misses allocates nothing.
- R6: The counter takes values 0 (strong not-taken) to 3 (strong taken), and a hit predicts taken for states 2 and 3. A trainable hit adds one when taken and subtracts one when not taken, saturating at 3 and at 0.
- R7: A taken trainable hit replaces the stored target. A not-taken trainable hit leaves the stored target unchanged.
- R8: An update with `updBranch` low that hits a valid row invalidates that row.
- R9: An update with `updBranch` low that misses changes no row.
- R10: When a lookup and an update address the same row in the same cycle, the lookup returns the contents from before the update.
- R11: With `updValid` low, the table is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lookupPc | input | AW | Fetch address to look up |
| predTaken | output | 1 | Registered predict-taken result |
| predTarget | output | AW | Registered predicted target, zero when not taken |
| updValid | input | 1 | A resolved instruction is reported this cycle |
| updPc | input | AW | Fetch address of the resolved instruction |
| updBranch | input | 1 | Resolved instruction is a trainable branch |
| updTaken | input | 1 | Resolved branch was taken |
| updTarget | input | AW | Actual target of the resolved branch |

## Verification
On every cycle the assertions check the update decisions at the point where control meets storage:
- invalidation happens only on a non-branch hit;
- allocation happens only for taken misses and starts at weakly taken;
- counter steps move in the direction of the outcome;
- the target is never rewritten on a not-taken outcome;
- nothing is written when no update is reported.

Only the bench scenarios can show the effects of these decisions at the ports. These are index/tag aliasing, the one-cycle lookup latency, the old-contents result when a lookup and an update collide on a row, and saturation over several updates. The bench compares every lookup against a reference table model.

// File: rtl/bp_pkg.sv
`timescale 1ns/1ps
package bp_pkg;

  // Direction state; the upper bit gives the prediction.
  typedef enum logic [1:0] {
    CtrStrongNt = 2'd0,
    CtrWeakNt   = 2'd1,
    CtrWeakT    = 2'd2,
    CtrStrongT  = 2'd3
  } ctr_e;

  // Strobes from control to storage for the row addressed by the update.
  typedef struct packed {
    logic write;      // set valid, write tag and counter
    logic clear;      // drop valid
    logic setTarget;  // also write the target
    ctr_e ctr;        // counter value to store
  } tblStrobe_t;

endpackage

// File: rtl/bp_table.sv
`timescale 1ns/1ps
module bp_table
  import bp_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = 32,
  localparam int IDXW = $clog2(DEPTH),
  localparam int TAGW = AW - IDXW - 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IDXW-1:0] lkIdx,
  input  logic [TAGW-1:0] lkTag,
  input  logic [IDXW-1:0] upIdx,
  input  logic [TAGW-1:0] upTag,
  input  logic [AW-1:0]   upTarget,
  input  tblStrobe_t      stb,
  output logic            lkHitQ,
  output ctr_e            lkCtrQ,
  output logic [AW-1:0]   lkTargetQ,
  output logic            upHit,
  output ctr_e            upCtr
);

  logic [DEPTH-1:0] validQ;
  logic [TAGW-1:0]  tagMem [DEPTH];
  ctr_e             ctrMem [DEPTH];
  logic [AW-1:0]    tgtMem [DEPTH];

  // Only the valid bits are reset; the payload is qualified by them.
  always_ff @(posedge clk) begin
    if (rst) begin
      validQ <= '0;
    end else if (stb.write) begin
      validQ[upIdx] <= 1'b1;
    end else if (stb.clear) begin
      validQ[upIdx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.write) begin
      tagMem[upIdx] <= upTag;
      ctrMem[upIdx] <= stb.ctr;
      if (stb.setTarget) begin
        tgtMem[upIdx] <= upTarget;
      end
    end
  end

  // Update-side read for the read-modify-write of the counter.
  always_comb begin
    upHit = validQ[upIdx] && (tagMem[upIdx] == upTag);
    upCtr = ctrMem[upIdx];
  end

  // Lookup-side read is registered: it samples the rows as they stand
  // before this edge's write.
  always_ff @(posedge clk) begin
    if (rst) begin
      lkHitQ    <= 1'b0;
      lkCtrQ    <= CtrStrongNt;
      lkTargetQ <= '0;
    end else begin
      lkHitQ    <= validQ[lkIdx] && (tagMem[lkIdx] == lkTag);
      lkCtrQ    <= ctrMem[lkIdx];
      lkTargetQ <= tgtMem[lkIdx];
    end
  end

endmodule

// File: rtl/bp_ctrl.sv
`timescale 1ns/1ps
module bp_ctrl
  import bp_pkg::*;
(
  input  logic       updValid,
  input  logic       updBranch,
  input  logic       updTaken,
  input  logic       upHit,
  input  ctr_e       upCtr,
  output tblStrobe_t stb
);

  ctr_e ctrUp;
  ctr_e ctrDown;

  always_comb begin
    ctrUp   = (upCtr == CtrStrongT)  ? CtrStrongT  : ctr_e'(upCtr + 2'd1);
    ctrDown = (upCtr == CtrStrongNt) ? CtrStrongNt : ctr_e'(upCtr - 2'd1);
  end

  always_comb begin
    stb = '0;
    if (updValid) begin
      if (upHit) begin
        if (!updBranch) begin
          // The row claimed a branch that is not a trainable one: drop it.
          stb.clear = 1'b1;
        end else begin
          stb.write     = 1'b1;
          stb.setTarget = updTaken;
          stb.ctr       = updTaken ? ctrUp : ctrDown;
        end
      end else if (updBranch && updTaken) begin
        stb.write     = 1'b1;
        stb.setTarget = 1'b1;
        stb.ctr       = CtrWeakT;
      end
    end
  end

endmodule

// File: rtl/bp_predictor.sv
`timescale 1ns/1ps
module bp_predictor
  import bp_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] lookupPc,
  output logic          predTaken,
  output logic [AW-1:0] predTarget,
  input  logic          updValid,
  input  logic [AW-1:0] updPc,
  input  logic          updBranch,
  input  logic          updTaken,
  input  logic [AW-1:0] updTarget
);

  localparam int IDXW = $clog2(DEPTH);
  localparam int TAGW = AW - IDXW - 2;

  tblStrobe_t    stb;
  logic          upHit;
  ctr_e          upCtr;
  logic          lkHitQ;
  ctr_e          lkCtrQ;
  logic [AW-1:0] lkTargetQ;
  logic          unusedLowBits;

  assign unusedLowBits = ^{lookupPc[1:0], updPc[1:0]};

  bp_table #(.DEPTH(DEPTH), .AW(AW)) uTable (
    .clk      (clk),
    .rst      (rst),
    .lkIdx    (lookupPc[IDXW+1:2]),
    .lkTag    (lookupPc[AW-1:IDXW+2]),
    .upIdx    (updPc[IDXW+1:2]),
    .upTag    (updPc[AW-1:IDXW+2]),
    .upTarget (updTarget),
    .stb      (stb),
    .lkHitQ   (lkHitQ),
    .lkCtrQ   (lkCtrQ),
    .lkTargetQ(lkTargetQ),
    .upHit    (upHit),
    .upCtr    (upCtr)
  );

  bp_ctrl uCtrl (
    .updValid (updValid),
    .updBranch(updBranch),
    .updTaken (updTaken),
    .upHit    (upHit),
    .upCtr    (upCtr),
    .stb      (stb)
  );

  always_comb begin
    predTaken  = lkHitQ && lkCtrQ[1];
    predTarget = predTaken ? lkTargetQ : '0;
  end

endmodule

// File: rtl/bp_predictor_chk.sv
`timescale 1ns/1ps
module bp_predictor_chk
  import bp_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       updValid,
  input logic       updBranch,
  input logic       updTaken,
  input logic       upHit,
  input ctr_e       upCtr,
  input tblStrobe_t stb,
  input logic       predTaken
);

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !predTaken);

  a_r8_clear_on_nonbranch_hit: assert property (@(posedge clk) disable iff (rst)
    stb.clear |-> (updValid && upHit && !updBranch));

  a_r5_no_alloc_not_taken: assert property (@(posedge clk) disable iff (rst)
    (updValid && updBranch && !updTaken && !upHit) |-> !stb.write);

  a_r4_alloc_weak_taken: assert property (@(posedge clk) disable iff (rst)
    (stb.write && !upHit) |-> (stb.ctr == CtrWeakT && stb.setTarget && updTaken));

  a_r6_ctr_direction: assert property (@(posedge clk) disable iff (rst)
    (stb.write && upHit) |-> (updTaken ? (stb.ctr >= upCtr) : (stb.ctr <= upCtr)));

  a_r7_keep_target_not_taken: assert property (@(posedge clk) disable iff (rst)
    (stb.write && !updTaken) |-> !stb.setTarget);

  a_r11_idle_no_change: assert property (@(posedge clk) disable iff (rst)
    !updValid |-> (!stb.write && !stb.clear));

  a_r8_write_clear_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(stb.write && stb.clear));

endmodule

bind bp_predictor bp_predictor_chk uChk (
  .clk      (clk),
  .rst      (rst),
  .updValid (updValid),
  .updBranch(updBranch),
  .updTaken (updTaken),
  .upHit    (upHit),
  .upCtr    (upCtr),
  .stb      (stb),
  .predTaken(predTaken)
);

// File: tb/tb_bp_predictor.sv
`timescale 1ns/1ps
module tb_bp_predictor;

  localparam int DEPTH = 16;
  localparam int AW    = 32;
  localparam int IDXW  = $clog2(DEPTH);
  localparam int TAGW  = AW - IDXW - 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] lookupPc = '0;
  logic          predTaken;
  logic [AW-1:0] predTarget;
  logic          updValid = 1'b0;
  logic [AW-1:0] updPc = '0;
  logic          updBranch = 1'b0;
  logic          updTaken = 1'b0;
  logic [AW-1:0] updTarget = '0;

  int total = 0;
  int bad   = 0;

  // Reference table
  logic            refValid [DEPTH];
  logic [TAGW-1:0] refTag   [DEPTH];
  logic [1:0]      refCtr   [DEPTH];
  logic [AW-1:0]   refTgt   [DEPTH];

  always #2.5 clk = ~clk;

  bp_predictor #(.DEPTH(DEPTH), .AW(AW)) dut (
    .clk(clk), .rst(rst), .lookupPc(lookupPc), .predTaken(predTaken),
    .predTarget(predTarget), .updValid(updValid), .updPc(updPc),
    .updBranch(updBranch), .updTaken(updTaken), .updTarget(updTarget)
  );

  function automatic logic [AW-1:0] mkPc(input int tagv, input int idx);
    return {TAGW'(tagv), IDXW'(idx), 2'b00};
  endfunction

  function automatic logic refHit(input logic [AW-1:0] pc);
    return refValid[pc[IDXW+1:2]] && refTag[pc[IDXW+1:2]] == pc[AW-1:IDXW+2];
  endfunction

  function automatic logic refPredTaken(input logic [AW-1:0] pc);
    return refHit(pc) && refCtr[pc[IDXW+1:2]] >= 2'd2;
  endfunction

  task automatic refUpdate(input logic uv, input logic ub, input logic ut,
                           input logic [AW-1:0] upc, input logic [AW-1:0] utg);
    int i;
    i = int'(upc[IDXW+1:2]);
    if (!uv) return;
    if (refHit(upc)) begin
      if (!ub) refValid[i] = 1'b0;
      else if (ut) begin
        if (refCtr[i] != 2'd3) refCtr[i] = refCtr[i] + 2'd1;
        refTgt[i] = utg;
      end else if (refCtr[i] != 2'd0) refCtr[i] = refCtr[i] - 2'd1;
    end else if (ub && ut) begin
      refValid[i] = 1'b1;
      refTag[i]   = upc[AW-1:IDXW+2];
      refCtr[i]   = 2'd2;
      refTgt[i]   = utg;
    end
  endtask

  // One cycle: drive lookup and update, check the lookup result after the edge.
  task automatic step(input logic [AW-1:0] lk, input logic uv, input logic ub,
                      input logic ut, input logic [AW-1:0] upc,
                      input logic [AW-1:0] utg, input string req);
    logic          expT;
    logic [AW-1:0] expTg;
    lookupPc = lk; updValid = uv; updBranch = ub; updTaken = ut;
    updPc = upc; updTarget = utg;
    expT  = refPredTaken(lk);
    expTg = expT ? refTgt[lk[IDXW+1:2]] : '0;
    refUpdate(uv, ub, ut, upc, utg);
    @(posedge clk);
    @(negedge clk);
    total++;
    if (predTaken !== expT || predTarget !== expTg) begin
      bad++;
      $display("FAIL %s: pc=%h actual taken=%b target=%h expected taken=%b target=%h",
               req, lk, predTaken, predTarget, expT, expTg);
    end
  endtask

  task automatic look(input logic [AW-1:0] lk, input string req);
    step(lk, 1'b0, 1'b0, 1'b0, '0, '0, req);
  endtask

  initial begin : watchdog
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [AW-1:0] pcA, pcB, pcC;
    for (int i = 0; i < DEPTH; i++) begin
      refValid[i] = 1'b0; refTag[i] = '0; refCtr[i] = 2'd0; refTgt[i] = '0;
    end
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state seen at the outputs
    total++;
    if (predTaken !== 1'b0 || predTarget !== '0) begin
      bad++;
      $display("FAIL R1: actual taken=%b target=%h expected taken=0 target=0",
               predTaken, predTarget);
    end
    for (int i = 0; i < DEPTH; i += 5) look(mkPc(i + 1, i), "R1");

    pcA = mkPc(3, 5);
    pcB = mkPc(9, 5);   // same index, other tag
    pcC = mkPc(4, 7);

    // R10: collide allocation with lookup of the same row: old contents (miss)
    step(pcA, 1'b1, 1'b1, 1'b1, pcA, 32'h0000_1000, "R10");
    // R2 / R4: next lookup sees weakly taken row with target
    look(pcA, "R2");
    look(pcA, "R4");
    // R3: other tag on same index does not hit
    look(pcB, "R3");
    // R6: weak taken -> weak not-taken -> predicts not taken
    step(pcA, 1'b1, 1'b1, 1'b0, pcA, 32'h0, "R10");
    look(pcA, "R6");
    // back up to strong taken and saturate
    step(pcA, 1'b1, 1'b1, 1'b1, pcA, 32'h0000_2000, "R6");
    step(pcA, 1'b1, 1'b1, 1'b1, pcA, 32'h0000_2000, "R6");
    step(pcA, 1'b1, 1'b1, 1'b1, pcA, 32'h0000_3000, "R7");
    look(pcA, "R7");
    // not taken from saturated: still taken, target kept
    step(pcA, 1'b1, 1'b1, 1'b0, pcA, 32'h0000_9999, "R6");
    look(pcA, "R7");
    // R5: not-taken miss allocates nothing
    step(pcB, 1'b1, 1'b1, 1'b0, pcB, 32'h0000_4000, "R5");
    look(pcB, "R5");
    // R9: non-branch miss changes nothing; row A kept
    step(pcC, 1'b1, 1'b0, 1'b1, pcC, 32'h0000_5000, "R9");
    look(pcC, "R9");
    look(pcA, "R9");
    // R11: no update reported
    step(pcC, 1'b0, 1'b1, 1'b1, pcC, 32'h0000_6000, "R11");
    look(pcC, "R11");
    // R8: non-branch hit invalidates
    step(pcA, 1'b1, 1'b0, 1'b0, pcA, 32'h0, "R8");
    look(pcA, "R8");
    // saturate at strong not-taken
    step(pcC, 1'b1, 1'b1, 1'b1, pcC, 32'h0000_7000, "R6");
    for (int k = 0; k < 4; k++) step(pcC, 1'b1, 1'b1, 1'b0, pcC, 32'h0, "R6");
    step(pcC, 1'b1, 1'b1, 1'b1, pcC, 32'h0000_7100, "R6");
    look(pcC, "R6");

    // Random mix over a small address pool for aliasing and collisions
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] lk, up;
      lk = mkPc($urandom_range(0, 2), $urandom_range(0, DEPTH - 1));
      up = ($urandom_range(0, 3) == 0) ? lk
           : mkPc($urandom_range(0, 2), $urandom_range(0, DEPTH - 1));
      step(lk, $urandom_range(0, 9) < 7, $urandom_range(0, 9) < 8,
           $urandom_range(0, 9) < 6, up, {$urandom(), 2'b00} >> 2 << 2, "R6");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule